// File: doc/BRIEF.md
# Peripheral Power Gating Controller

This block decides, for each of a set of peripheral modules, whether the module is clocked, whether it runs, and whether its registers can be reached. Each module has three controls. A disable bit, held centrally, removes the module's clock and closes its register window. A run-enable bit, held in the module's own control register, stops only the module's function and leaves its registers usable. A stop-in-idle bit, also in the module's control register, halts the module only while the system idle input is high. Some module slots are built without a run-enable bit. For those slots only the disable and stop-in-idle controls apply.

A simple register bus reaches the central disable register and a small bank of stub registers for each module. The stubs stand in for the real peripheral registers. The bus filters accesses by disable state: writes to a disabled module are dropped, and reads from it return zero. Each read completes with a single registered response one cycle after the request. A disabled module's stubs are held at reset, so the module comes back with reset contents when it is enabled again.

Top module: `pgate_ctrl`

## Requirements
- R1: After reset, all disable bits and all stub registers are zero. All clock and register-access enables are high. Run enables are high only for slots built without a run-enable bit.
- R2: A module's clock enable is high exactly when its disable bit is clear and it is not the case that idle is high while its stop-in-idle bit is set. The stop-in-idle bit is bit 1 of the module's control register (stub word 0).
- R3: A module with a run-enable bit (bit 0 of its control register) has run enable equal to its clock enable ANDed with that bit. Its registers can be read and written while that bit is clear.
- R4: In a slot built without a run-enable bit, control bit 0 always reads zero and ignores writes, and run enable follows clock enable.
- R5: A module's register-access enable is high exactly when its disable bit is clear.
- R6: Writes to a disabled module's registers have no effect. After re-enable, they read back as zero.
- R7: Setting a module's disable bit clears its stub registers, so contents written before the disable do not survive it.
- R8: A read from a disabled module returns zero, with the normal one-cycle response and no error.
- R9: Every read request produces bus_rvalid for exactly one cycle, in the cycle after the request. Writes produce none.
- R10: The disable register sits at module select N_MOD, word 0. Bit i disables module i, and unused upper bits read zero. The bus address is {module select, word index}. Any address outside the modules and the disable register reads zero.
- R11: With idle high, a module whose disable and stop-in-idle bits are clear keeps its clock enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| idle | input | 1 | System idle indication |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | {module select, word index} |
| bus_wdata | input | DATA_W | Write data |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | DATA_W | Read response data |
| clk_en | output | N_MOD | Per-module clock enable |
| run_en | output | N_MOD | Per-module function enable |
| reg_acc_en | output | N_MOD | Per-module register-access enable |

## Verification
Suppose a disable bit were stuck, or a stub failed to clear. The first sign at the ports would be a wrong clock or access enable in the cycle after the write that set the bit. After re-enable, the stale contents would show up on the first read, one cycle after that read is issued. Errors in the stop-in-idle bit or the run-enable bit appear on clk_en or run_en as soon as idle toggles. Read filtering and latency errors show up as a wrong or missing response in the cycle after any read.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  // Bit positions inside each module's control word (stub word 0)
  localparam int unsigned CTRL_RUN_BIT   = 0;
  localparam int unsigned CTRL_ISTOP_BIT = 1;

  typedef enum logic [1:0] {
    ACC_NONE     = 2'd0,
    ACC_MOD      = 2'd1,
    ACC_DISREG   = 2'd2,
    ACC_UNMAPPED = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/pgate_decode.sv
module pgate_decode
  import pgate_pkg::*;
#(
  parameter int unsigned N_MOD  = 4,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned REG_W  = 1,
  parameter int unsigned ADDR_W = SEL_W + REG_W
) (
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  output acc_kind_e         acc_kind,
  output logic [N_MOD-1:0]  mod_hit,
  output logic [REG_W-1:0]  word_idx
);
  logic [SEL_W-1:0] sel;

  assign sel      = bus_addr[ADDR_W-1:REG_W];
  assign word_idx = bus_addr[REG_W-1:0];

  for (genvar i = 0; i < N_MOD; i++) begin : g_hit
    assign mod_hit[i] = bus_valid && (sel == SEL_W'(i));
  end

  always_comb begin
    if (!bus_valid) begin
      acc_kind = ACC_NONE;
    end else if (sel < SEL_W'(N_MOD)) begin
      acc_kind = ACC_MOD;
    end else if ((sel == SEL_W'(N_MOD)) && (word_idx == '0)) begin
      acc_kind = ACC_DISREG;
    end else begin
      acc_kind = ACC_UNMAPPED;
    end
  end
endmodule

// File: rtl/pgate_stub.sv
module pgate_stub
  import pgate_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned REGS    = 2,
  parameter int unsigned REG_W   = 1,
  parameter bit          HAS_RUN = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dis,
  input  logic                   wr_hit,
  input  logic [REG_W-1:0]       word_idx,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rd_word,
  output logic                   run_bit,
  output logic                   istop_bit,
  output logic [REGS*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] regs_q [REGS];
  logic [DATA_W-1:0] regs_d [REGS];
  logic              upd;

  assign upd = dis | wr_hit;

  always_comb begin
    for (int r = 0; r < REGS; r++) begin
      regs_d[r] = regs_q[r];
      if (dis) begin
        regs_d[r] = '0;
      end else if (wr_hit && (word_idx == REG_W'(r))) begin
        regs_d[r] = wdata;
      end
    end
    if (!HAS_RUN) begin
      regs_d[0][CTRL_RUN_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < REGS; r++) regs_q[r] <= '0;
    end else if (upd) begin
      for (int r = 0; r < REGS; r++) regs_q[r] <= regs_d[r];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int r = 0; r < REGS; r++) begin
      if (word_idx == REG_W'(r)) rd_word = regs_q[r];
    end
  end

  for (genvar r = 0; r < REGS; r++) begin : g_flat
    assign regs_flat[r*DATA_W +: DATA_W] = regs_q[r];
  end

  if (HAS_RUN) begin : g_run
    assign run_bit = regs_q[0][CTRL_RUN_BIT];
  end else begin : g_norun
    assign run_bit = 1'b1;
  end
  assign istop_bit = regs_q[0][CTRL_ISTOP_BIT];
endmodule

// File: rtl/pgate_gate.sv
module pgate_gate #(
  parameter int unsigned N_MOD = 4
) (
  input  logic             idle,
  input  logic [N_MOD-1:0] dis,
  input  logic [N_MOD-1:0] run_bits,
  input  logic [N_MOD-1:0] istop_bits,
  output logic [N_MOD-1:0] clk_en,
  output logic [N_MOD-1:0] run_en,
  output logic [N_MOD-1:0] reg_acc_en
);
  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    logic idle_halt;
    assign idle_halt     = idle & istop_bits[i];
    assign clk_en[i]     = ~dis[i] & ~idle_halt;
    assign run_en[i]     = clk_en[i] & run_bits[i];
    assign reg_acc_en[i] = ~dis[i];
  end
endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
  import pgate_pkg::*;
#(
  parameter int unsigned     N_MOD   = 4,
  parameter int unsigned     DATA_W  = 16,
  parameter int unsigned     REGS    = 2,
  parameter logic [N_MOD-1:0] HAS_RUN = {1'b0, {(N_MOD-1){1'b1}}},
  localparam int unsigned    SEL_W   = $clog2(N_MOD + 1),
  localparam int unsigned    REG_W   = (REGS > 1) ? $clog2(REGS) : 1,
  localparam int unsigned    ADDR_W  = SEL_W + REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rvalid,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_MOD-1:0]  clk_en,
  output logic [N_MOD-1:0]  run_en,
  output logic [N_MOD-1:0]  reg_acc_en
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // Address decode
  acc_kind_e          acc_kind;
  logic [N_MOD-1:0]   mod_hit;
  logic [REG_W-1:0]   word_idx;
  logic [SEL_W-1:0]   bus_sel;

  assign bus_sel = bus_addr[ADDR_W-1:REG_W];

  pgate_decode #(
    .N_MOD(N_MOD), .SEL_W(SEL_W), .REG_W(REG_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .bus_valid(bus_valid),
    .bus_addr (bus_addr),
    .acc_kind (acc_kind),
    .mod_hit  (mod_hit),
    .word_idx (word_idx)
  );

  // Central disable register
  logic [N_MOD-1:0] dis_q, dis_d;
  logic             dis_upd;

  assign dis_upd = (acc_kind == ACC_DISREG) && bus_write;

  always_comb begin
    dis_d = dis_q;
    if (dis_upd) dis_d = bus_wdata[N_MOD-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  dis_q <= '0;
    else if (dis_upd) dis_q <= dis_d;
  end

  // Per-module stub registers
  logic [DATA_W-1:0]      stub_rd   [N_MOD];
  logic [REGS*DATA_W-1:0] stub_flat [N_MOD];
  logic [N_MOD-1:0]       run_bits;
  logic [N_MOD-1:0]       istop_bits;
  logic [N_MOD-1:0]       wr_hit;

  for (genvar i = 0; i < N_MOD; i++) begin : g_stub
    assign wr_hit[i] = (acc_kind == ACC_MOD) && bus_write && mod_hit[i] && !dis_q[i];

    pgate_stub #(
      .DATA_W(DATA_W), .REGS(REGS), .REG_W(REG_W), .HAS_RUN(HAS_RUN[i])
    ) u_stub (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .dis      (dis_q[i]),
      .wr_hit   (wr_hit[i]),
      .word_idx (word_idx),
      .wdata    (bus_wdata),
      .rd_word  (stub_rd[i]),
      .run_bit  (run_bits[i]),
      .istop_bit(istop_bits[i]),
      .regs_flat(stub_flat[i])
    );
  end

  // Enable generation
  pgate_gate #(.N_MOD(N_MOD)) u_gate (
    .idle      (idle),
    .dis       (dis_q),
    .run_bits  (run_bits),
    .istop_bits(istop_bits),
    .clk_en    (clk_en),
    .run_en    (run_en),
    .reg_acc_en(reg_acc_en)
  );

  // Read path: filtered, one registered response per read
  logic [DATA_W-1:0] mod_rd;
  logic              mod_dis;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rd_req;
  logic              rvalid_q;

  assign rd_req = bus_valid && !bus_write;

  always_comb begin
    mod_rd  = '0;
    mod_dis = 1'b0;
    for (int i = 0; i < N_MOD; i++) begin
      if (mod_hit[i]) begin
        mod_rd  = mod_rd | stub_rd[i];
        mod_dis = mod_dis | dis_q[i];
      end
    end
  end

  always_comb begin
    unique case (acc_kind)
      ACC_MOD:    rdata_d = mod_dis ? '0 : mod_rd;
      ACC_DISREG: rdata_d = DATA_W'(dis_q);
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rvalid_q <= 1'b0;
    else             rvalid_q <= rd_req;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else if (rd_req) rdata_q <= rdata_d;
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rvalid_q ? rdata_q : '0;
endmodule

// File: rtl/pgate_ctrl_chk.sv
module pgate_ctrl_chk #(
  parameter int unsigned      N_MOD   = 4,
  parameter int unsigned      DATA_W  = 16,
  parameter int unsigned      REGS    = 2,
  parameter int unsigned      SEL_W   = 3,
  parameter logic [N_MOD-1:0] HAS_RUN = '1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   idle,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic [SEL_W-1:0]       bus_sel,
  input logic                   bus_rvalid,
  input logic [DATA_W-1:0]      bus_rdata,
  input logic [N_MOD-1:0]       dis_q,
  input logic [N_MOD-1:0]       istop_bits,
  input logic [N_MOD-1:0]       clk_en,
  input logic [N_MOD-1:0]       run_en,
  input logic [N_MOD-1:0]       reg_acc_en,
  input logic [REGS*DATA_W-1:0] stub_flat [N_MOD]
);
  p_rd_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);
  p_no_spurious_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);

  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    p_dis_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dis_q[i] |-> (!clk_en[i] && !run_en[i]));
    p_idle_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && istop_bits[i]) |-> !clk_en[i]);
    p_idle_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!dis_q[i] && !istop_bits[i]) |-> clk_en[i]);
    p_run_needs_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run_en[i] |-> clk_en[i]);
    p_acc_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dis_q[i] |-> !reg_acc_en[i]);
    p_clear_on_dis_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dis_q[i] |=> (stub_flat[i] == '0));
    p_dis_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && (bus_sel == SEL_W'(i)) && dis_q[i])
        |=> (bus_rdata == '0));
    if (!HAS_RUN[i]) begin : g_norun
      p_norun_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en[i] |-> run_en[i]);
    end
  end
endmodule

bind pgate_ctrl pgate_ctrl_chk #(
  .N_MOD(N_MOD), .DATA_W(DATA_W), .REGS(REGS), .SEL_W(SEL_W), .HAS_RUN(HAS_RUN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .idle      (idle),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_sel   (bus_sel),
  .bus_rvalid(bus_rvalid),
  .bus_rdata (bus_rdata),
  .dis_q     (dis_q),
  .istop_bits(istop_bits),
  .clk_en    (clk_en),
  .run_en    (run_en),
  .reg_acc_en(reg_acc_en),
  .stub_flat (stub_flat)
);

// File: tb/pgate_ctrl_bench.sv
module pgate_ctrl_bench;
  localparam int N_MOD  = 4;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int DISREG = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              idle = 1'b0;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic              bus_rvalid;
  logic [DATA_W-1:0] bus_rdata;
  logic [N_MOD-1:0]  clk_en, run_en, reg_acc_en;

  always #10 clk = ~clk;

  pgate_ctrl u_pgate_ctrl (
    .clk(clk), .rst_n(rst_n), .idle(idle),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .clk_en(clk_en), .run_en(run_en), .reg_acc_en(reg_acc_en)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [DATA_W-1:0] data;
    int                cyc;
    string             tag;
  } exp_t;
  exp_t exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(int a, logic [DATA_W-1:0] d);
    @(posedge clk); #2;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(posedge clk); #2;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(int a, logic [DATA_W-1:0] exp, string tag);
    exp_t e;
    @(posedge clk); #2;
    e.data = exp; e.cyc = cyc; e.tag = tag;
    exp_q.push_back(e);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = ADDR_W'(a);
    @(posedge clk); #2;
    bus_valid = 1'b0;
  endtask

  task automatic enables(logic [3:0] ce, logic [3:0] re, logic [3:0] ae, string tag);
    #1;
    check({tag, " clk_en"}, 32'(clk_en), 32'(ce));
    check({tag, " run_en"}, 32'(run_en), 32'(re));
    check({tag, " reg_acc_en"}, 32'(reg_acc_en), 32'(ae));
  endtask

  // Monitor: pops expected read responses, checks data and one-cycle latency
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: unexpected rvalid actual=%h expected=none", bus_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " rdata"}, 32'(bus_rdata), 32'(e.data));
        check("R9 latency", 32'(cyc - e.cyc), 32'd1);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state (slot 3 has no run-enable bit)
    enables(4'b1111, 4'b1000, 4'b1111, "R1");
    bus_rd(DISREG, 16'h0000, "R1 disreg");
    bus_rd(0, 16'h0000, "R1 m0 ctrl");
    bus_rd(3, 16'h0000, "R1 m1 data");

    // R3 run-enable bit
    bus_wr(0, 16'h0001);
    enables(4'b1111, 4'b1001, 4'b1111, "R3 m0 run");
    // R4 slot without run-enable bit
    bus_wr(6, 16'hA5A5);
    bus_rd(6, 16'hA5A4, "R4 m3 ctrl bit0");
    enables(4'b1111, 4'b1001, 4'b1111, "R4 m3 runs");
    // R3 registers usable while not enabled
    bus_wr(5, 16'hBEEF);
    bus_rd(5, 16'hBEEF, "R3 m2 data while stopped");
    bus_wr(3, 16'h1234);
    bus_rd(3, 16'h1234, "R6 m1 data baseline");
    bus_rd(9, 16'h0000, "R10 unmapped");

    // R2 / R11 idle behaviour
    bus_wr(0, 16'h0003);
    enables(4'b1111, 4'b1001, 4'b1111, "R2 istop not idle");
    #2 idle = 1'b1;
    enables(4'b1110, 4'b1000, 4'b1111, "R2 R11 idle");
    #2 idle = 1'b0;
    enables(4'b1111, 4'b1001, 4'b1111, "R2 idle released");

    // R5 / R8 / R10 disable module 1
    bus_wr(DISREG, 16'h0002);
    enables(4'b1101, 4'b1001, 4'b1101, "R5 m1 disabled");
    bus_rd(3, 16'h0000, "R8 m1 read while disabled");
    bus_rd(DISREG, 16'h0002, "R10 disreg readback");
    bus_wr(3, 16'h5555);
    bus_wr(DISREG, 16'h0000);
    enables(4'b1111, 4'b1001, 4'b1111, "R5 m1 reenabled");
    bus_rd(3, 16'h0000, "R6 R7 m1 data after reenable");
    bus_rd(5, 16'hBEEF, "R7 m2 untouched");

    // R7 control word also cleared: disable m0, re-enable, run bit gone
    bus_wr(DISREG, 16'h0001);
    bus_wr(DISREG, 16'h0000);
    enables(4'b1111, 4'b1000, 4'b1111, "R7 m0 ctrl cleared");

    // R10 upper disable bits read zero; all gated
    bus_wr(DISREG, 16'hFFFF);
    enables(4'b0000, 4'b0000, 4'b0000, "R2 R5 all disabled");
    bus_rd(DISREG, 16'h000F, "R10 disreg width");
    bus_rd(6, 16'h0000, "R8 m3 read while disabled");
    bus_wr(DISREG, 16'h0000);

    repeat (3) @(posedge clk);
    check("R9 all responses seen", 32'(exp_q.size()), 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule